// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address. It decides which translation path applies, picks the matching physical address, and then screens the result for illegal high bits and for the uncached region. It has four paths: an escape for privileged-code addresses, a pass-through for physical-mode fetches, a kernel-only direct-mapped superpage window, and a page lookup through an attached translation buffer.

The translation buffer sits outside the block. During the request cycle the block presents the virtual page number and the address-space number on a lookup port. The buffer answers in the same cycle with a hit flag, a physical page number and a four-bit read-enable mask that holds one bit per privilege mode. Each request gives one response one cycle later. The response carries the physical address, an uncacheable flag and a one-hot fault code. Filling the buffer on a miss is left to the logic outside this block.

Top module: `iatu`

## Requirements
- R1: Each cycle with `req_valid_i` high produces `rsp_valid_o` high on the next cycle. A cycle without a request produces `rsp_valid_o` low on the next cycle. After reset all outputs read zero.
- R2: A fetch address with bit 0 set is privileged code. This check takes priority over every other path, including physical mode and the canonical check. Its result is the address with bits 1:0 cleared and masked to bits 43:0. The fault code is zero, `uncache_o` is 0, and the uncached-region step does not apply.
- R3: When R2 does not apply and `phys_mode_i` is high, the physical address equals the virtual address. R8 to R10 then apply to it.
- R4: In virtual mode, an address whose bits 63:47 are not all equal raises an access violation. The access violation is fault bit 0, so `fault_o` = 4'b0001.
- R5: A canonical address with bits 47:41 equal to 7'h7E is a superpage. If the mode is not kernel (kernel mode is 2'd0), it raises an access violation. In kernel mode the physical address is bits 43:0 of the address. If bit 40 of that value is 1, bits 43:40 are forced to 1. If bit 40 is 0, bits 63:40 are cleared.
- R6: For every request, `tlb_vpn_o` equals address bits 47:13 and `tlb_asn_o` equals `asn_i` in the same cycle. On the lookup path, a miss raises a translation-miss fault. The miss is fault bit 1, so `fault_o` = 4'b0010.
- R7: On a lookup hit, the physical address is {ppn, address bits 12:2, 2'b00}. If bit `mode_i` of `tlb_rd_en_i` is clear, the fetch raises an access violation.
- R8: A translated address with any bit at position 44 or above set raises a machine check. The machine check is fault bit 2, so `fault_o` = 4'b0100.
- R9: A translated address with bit 43 set and bits 43:36 equal to 8'h81 lies in register space. It raises an unimplemented-space fault. That fault is bit 3, so `fault_o` = 4'b1000.
- R10: A translated address with bit 43 set outside register space sets `uncache_o`. It is returned with bits 42:35 cleared.
- R11: `fault_o` always has at most one bit set. `uncache_o` is never high together with a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| va_i | input | 64 | Fetch virtual address |
| phys_mode_i | input | 1 | Treat the address as physical |
| mode_i | input | 2 | Current privilege mode, 0 = kernel |
| asn_i | input | 8 | Current address-space number |
| tlb_vpn_o | output | 35 | Lookup port: virtual page number |
| tlb_asn_o | output | 8 | Lookup port: address-space number |
| tlb_hit_i | input | 1 | Lookup port: entry found |
| tlb_ppn_i | input | 31 | Lookup port: physical page number |
| tlb_rd_en_i | input | 4 | Lookup port: read enable per mode |
| rsp_valid_o | output | 1 | Response valid |
| pa_o | output | 64 | Physical address, meaningful when no fault |
| uncache_o | output | 1 | Fetch targets uncached space |
| fault_o | output | 4 | One-hot fault: 0 access, 1 miss, 2 machine check, 3 unimplemented |

## Verification
The lookup-port outputs are combinational. The bench checks them one time unit after it drives the address, inside the request cycle. Every other result is registered once, so it is due at the first rising edge after the request. The bench drives inputs on the falling edge, waits through that rising edge, and samples on the next falling edge, when the response is stable. It lowers the request at that point so that the idle cycles afterwards can confirm that the valid flag drops.

// File: rtl/iatu_pkg.sv
package iatu_pkg;
  typedef enum logic [1:0] {
    PATH_PAL   = 2'd0,
    PATH_PHYS  = 2'd1,
    PATH_SUPER = 2'd2,
    PATH_TLB   = 2'd3
  } path_e;

  localparam int FLT_W     = 4;
  localparam int FLT_ACV   = 0;
  localparam int FLT_MISS  = 1;
  localparam int FLT_MCHK  = 2;
  localparam int FLT_UNIMP = 3;

  localparam int KERNEL_MODE = 0;
endpackage

// File: rtl/iatu_classify.sv
module iatu_classify
  import iatu_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int SP_W    = 7,
  parameter logic [SP_W-1:0] SP_TAG = 7'h7E,
  parameter int MODE_W  = 2,
  parameter int SP_LO   = VA_IMPL - SP_W
) (
  input  logic [VA_W-1:SP_LO] va_hi_i,
  input  logic                va0_i,
  input  logic                phys_i,
  input  logic [MODE_W-1:0]   mode_i,
  output path_e               path_o,
  output logic                acv_o
);
  localparam int EXT_W = VA_W - VA_IMPL + 1;

  logic [EXT_W-1:0] ext;
  logic canon, super_hit, kernel;

  assign ext       = va_hi_i[VA_W-1:VA_IMPL-1];
  assign canon     = (ext == '0) || (ext == '1);
  assign super_hit = (va_hi_i[VA_IMPL-1:SP_LO] == SP_TAG);
  assign kernel    = (mode_i == MODE_W'(KERNEL_MODE));

  always_comb begin
    path_o = PATH_TLB;
    acv_o  = 1'b0;
    if (va0_i) begin
      path_o = PATH_PAL;
    end else if (phys_i) begin
      path_o = PATH_PHYS;
    end else if (!canon) begin
      acv_o = 1'b1;
    end else if (super_hit) begin
      path_o = PATH_SUPER;
      acv_o  = !kernel;
    end
  end
endmodule

// File: rtl/iatu_form.sv
module iatu_form
  import iatu_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_IMPL    = 44,
  parameter int PG_W       = 13,
  parameter int MODE_W     = 2,
  parameter int SP_EXT_BIT = 40,
  parameter int PPN_W      = PA_IMPL - PG_W,
  parameter int NMODE      = 1 << MODE_W
) (
  input  path_e             path_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              hit_i,
  input  logic [PPN_W-1:0]  ppn_i,
  input  logic [NMODE-1:0]  rd_en_i,
  output logic [VA_W-1:0]   pa_o,
  output logic              miss_o,
  output logic              perm_o
);
  localparam int EXT_HI_W = PA_IMPL - SP_EXT_BIT;
  localparam logic [VA_W-1:0] IMPL_MASK = {{(VA_W-PA_IMPL){1'b0}}, {PA_IMPL{1'b1}}};

  logic [VA_W-1:0] pa_pal, pa_super, pa_tlb;
  logic [NMODE-1:0] mode_sel;

  // one-hot mode decode against the per-mode enable mask
  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    assign mode_sel[m] = (mode_i == MODE_W'(m));
  end

  assign pa_pal = va_i & IMPL_MASK & ~VA_W'(3);
  assign pa_tlb = {{(VA_W-PA_IMPL){1'b0}}, ppn_i, va_i[PG_W-1:2], 2'b00};

  always_comb begin
    pa_super = va_i & IMPL_MASK;
    if (pa_super[SP_EXT_BIT]) pa_super[PA_IMPL-1:SP_EXT_BIT] = {EXT_HI_W{1'b1}};
    else                      pa_super[PA_IMPL-1:SP_EXT_BIT] = '0;
  end

  always_comb begin
    unique case (path_i)
      PATH_PAL:   pa_o = pa_pal;
      PATH_PHYS:  pa_o = va_i;
      PATH_SUPER: pa_o = pa_super;
      default:    pa_o = pa_tlb;
    endcase
  end

  assign miss_o = (path_i == PATH_TLB) && !hit_i;
  assign perm_o = (path_i == PATH_TLB) && hit_i && ((rd_en_i & mode_sel) == '0);
endmodule

// File: rtl/iatu_post.sv
module iatu_post #(
  parameter int VA_W      = 64,
  parameter int PA_IMPL   = 44,
  parameter int IPR_LSB   = 36,
  parameter int IPR_W     = PA_IMPL - IPR_LSB,
  parameter logic [IPR_W-1:0] IPR_TAG = 8'h81,
  parameter int UC_CLR_LO = 35
) (
  input  logic [VA_W-1:0] pa_i,
  output logic [VA_W-1:0] pa_o,
  output logic            uc_o,
  output logic            mchk_o,
  output logic            unimp_o
);
  localparam int UC_BIT = PA_IMPL - 1;
  localparam logic [VA_W-1:0] CLR_MASK =
    ((VA_W'(1) << (UC_BIT - UC_CLR_LO)) - VA_W'(1)) << UC_CLR_LO;

  logic ipr, uc_bit;

  assign mchk_o  = |pa_i[VA_W-1:PA_IMPL];
  assign uc_bit  = pa_i[UC_BIT];
  assign ipr     = (pa_i[PA_IMPL-1:IPR_LSB] == IPR_TAG);
  assign unimp_o = !mchk_o && uc_bit && ipr;
  assign uc_o    = !mchk_o && uc_bit && !ipr;
  assign pa_o    = uc_o ? (pa_i & ~CLR_MASK) : pa_i;
endmodule

// File: rtl/iatu.sv
module iatu
  import iatu_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_IMPL    = 48,
  parameter int PA_IMPL    = 44,
  parameter int PG_W       = 13,
  parameter int ASN_W      = 8,
  parameter int MODE_W     = 2,
  parameter int SP_W       = 7,
  parameter logic [SP_W-1:0] SP_TAG = 7'h7E,
  parameter int SP_EXT_BIT = 40,
  parameter int IPR_LSB    = 36,
  parameter logic [PA_IMPL-IPR_LSB-1:0] IPR_TAG = 8'h81,
  parameter int UC_CLR_LO  = 35,
  parameter int VPN_W      = VA_IMPL - PG_W,
  parameter int PPN_W      = PA_IMPL - PG_W,
  parameter int NMODE      = 1 << MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              phys_mode_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ASN_W-1:0]  asn_i,
  output logic [VPN_W-1:0]  tlb_vpn_o,
  output logic [ASN_W-1:0]  tlb_asn_o,
  input  logic              tlb_hit_i,
  input  logic [PPN_W-1:0]  tlb_ppn_i,
  input  logic [NMODE-1:0]  tlb_rd_en_i,
  output logic              rsp_valid_o,
  output logic [VA_W-1:0]   pa_o,
  output logic              uncache_o,
  output logic [FLT_W-1:0]  fault_o
);
  localparam int SP_LO = VA_IMPL - SP_W;

  path_e           path;
  logic            cls_acv, miss, perm, mchk, unimp, post_uc;
  logic [VA_W-1:0] pa_raw, pa_post, pa_d;
  logic [FLT_W-1:0] flt_d;
  logic            uc_d;

  assign tlb_vpn_o = va_i[VA_IMPL-1:PG_W];
  assign tlb_asn_o = asn_i;

  iatu_classify #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .SP_W(SP_W), .SP_TAG(SP_TAG),
    .MODE_W(MODE_W), .SP_LO(SP_LO)
  ) u_cls (
    .va_hi_i (va_i[VA_W-1:SP_LO]),
    .va0_i   (va_i[0]),
    .phys_i  (phys_mode_i),
    .mode_i  (mode_i),
    .path_o  (path),
    .acv_o   (cls_acv)
  );

  iatu_form #(
    .VA_W(VA_W), .PA_IMPL(PA_IMPL), .PG_W(PG_W), .MODE_W(MODE_W),
    .SP_EXT_BIT(SP_EXT_BIT), .PPN_W(PPN_W), .NMODE(NMODE)
  ) u_form (
    .path_i  (path),
    .va_i    (va_i),
    .mode_i  (mode_i),
    .hit_i   (tlb_hit_i),
    .ppn_i   (tlb_ppn_i),
    .rd_en_i (tlb_rd_en_i),
    .pa_o    (pa_raw),
    .miss_o  (miss),
    .perm_o  (perm)
  );

  iatu_post #(
    .VA_W(VA_W), .PA_IMPL(PA_IMPL), .IPR_LSB(IPR_LSB),
    .IPR_W(PA_IMPL - IPR_LSB), .IPR_TAG(IPR_TAG), .UC_CLR_LO(UC_CLR_LO)
  ) u_post (
    .pa_i    (pa_raw),
    .pa_o    (pa_post),
    .uc_o    (post_uc),
    .mchk_o  (mchk),
    .unimp_o (unimp)
  );

  // fault priority follows the translation order; privileged code skips all checks
  always_comb begin
    flt_d = '0;
    if (path != PATH_PAL) begin
      if (cls_acv)    flt_d[FLT_ACV]   = 1'b1;
      else if (miss)  flt_d[FLT_MISS]  = 1'b1;
      else if (perm)  flt_d[FLT_ACV]   = 1'b1;
      else if (mchk)  flt_d[FLT_MCHK]  = 1'b1;
      else if (unimp) flt_d[FLT_UNIMP] = 1'b1;
    end
  end

  assign uc_d = (path != PATH_PAL) && (flt_d == '0) && post_uc;
  assign pa_d = (path == PATH_PAL) ? pa_raw : pa_post;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      pa_o        <= '0;
      uncache_o   <= 1'b0;
      fault_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        pa_o      <= pa_d;
        uncache_o <= uc_d;
        fault_o   <= flt_d;
      end
    end
  end
endmodule

// File: rtl/iatu_chk.sv
module iatu_chk #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int PA_IMPL = 44,
  parameter int MODE_W  = 2,
  parameter int FLT_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [VA_W-1:0]   va_i,
  input logic              phys_mode_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              tlb_hit_i,
  input logic              rsp_valid_o,
  input logic [VA_W-1:0]   pa_o,
  input logic              uncache_o,
  input logic [FLT_W-1:0]  fault_o
);
  logic canon, sp, virt;
  assign canon = (va_i[VA_W-1:VA_IMPL-1] == '0) || (va_i[VA_W-1:VA_IMPL-1] == '1);
  assign sp    = (va_i[VA_IMPL-1:VA_IMPL-7] == 7'h7E);
  assign virt  = req_valid_i && !va_i[0] && !phys_mode_i;

  p_rsp_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_pal_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && va_i[0]) |=> (fault_o == '0 && pa_o[1:0] == 2'b00 && !uncache_o));
  p_noncanon_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (virt && !canon) |=> (fault_o == FLT_W'(1)));
  p_super_user_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (virt && canon && sp && mode_i != '0) |=> (fault_o == FLT_W'(1)));
  p_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (virt && canon && !sp && !tlb_hit_i) |=> (fault_o == FLT_W'(2)));
  p_pa_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fault_o == '0) |-> (pa_o[VA_W-1:PA_IMPL] == '0));
  p_uc_shape_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncache_o |-> (pa_o[PA_IMPL-1] && pa_o[PA_IMPL-2:PA_IMPL-9] == '0));
  p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fault_o));
  p_uc_clean_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncache_o |-> (fault_o == '0));
endmodule

bind iatu iatu_chk #(
  .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_IMPL(PA_IMPL), .MODE_W(MODE_W), .FLT_W(iatu_pkg::FLT_W)
) u_chk (.*);

// File: tb/iatu_test.sv
`timescale 1ns/1ps
module iatu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] va = '0;
  logic        phys = 1'b0;
  logic [1:0]  mode = '0;
  logic [7:0]  asn = '0;
  logic [34:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic        hit = 1'b0;
  logic [30:0] ppn = '0;
  logic [3:0]  rd_en = '0;
  logic        rsp_valid;
  logic [63:0] pa;
  logic        uc;
  logic [3:0]  flt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iatu uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .va_i(va),
    .phys_mode_i(phys), .mode_i(mode), .asn_i(asn),
    .tlb_vpn_o(tlb_vpn), .tlb_asn_o(tlb_asn), .tlb_hit_i(hit),
    .tlb_ppn_i(ppn), .tlb_rd_en_i(rd_en),
    .rsp_valid_o(rsp_valid), .pa_o(pa), .uncache_o(uc), .fault_o(flt)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected result computed from the requirement text
  function automatic void model(input logic [63:0] v, input logic ph, input logic [1:0] md,
                                input logic ht, input logic [30:0] pp, input logic [3:0] rd,
                                output logic [63:0] e_pa, output logic e_uc, output logic [3:0] e_f);
    e_pa = '0; e_uc = 1'b0; e_f = '0;
    if (v[0]) begin e_pa = v & 64'h0000_0FFF_FFFF_FFFC; return; end       // R2
    if (ph) e_pa = v;                                                     // R3
    else if (!(v[63:47] == '0 || v[63:47] == '1)) begin e_f = 4'b0001; return; end // R4
    else if (v[47:41] == 7'h7E) begin                                     // R5
      if (md != 2'd0) begin e_f = 4'b0001; return; end
      e_pa = v & 64'h0000_0FFF_FFFF_FFFF;
      if (e_pa[40]) e_pa = e_pa | 64'h0000_0F00_0000_0000;
      else          e_pa = e_pa & 64'h0000_00FF_FFFF_FFFF;
    end else begin
      if (!ht) begin e_f = 4'b0010; return; end                           // R6
      e_pa = {20'd0, pp, v[12:2], 2'b00};                                 // R7
      if (!rd[md]) begin e_f = 4'b0001; return; end
    end
    if (e_pa[63:44] != '0) begin e_f = 4'b0100; return; end               // R8
    if (e_pa[43]) begin
      if (e_pa[43:36] == 8'h81) begin e_f = 4'b1000; return; end          // R9
      e_uc = 1'b1;                                                        // R10
      e_pa[42:35] = '0;
    end
  endfunction

  task automatic run(input string req, input logic [63:0] v, input logic ph, input logic [1:0] md,
                     input logic ht, input logic [30:0] pp, input logic [3:0] rd);
    logic [63:0] e_pa; logic e_uc; logic [3:0] e_f;
    model(v, ph, md, ht, pp, rd, e_pa, e_uc, e_f);
    @(negedge clk);
    req_valid = 1'b1; va = v; phys = ph; mode = md; hit = ht; ppn = pp; rd_en = rd;
    asn = v[20:13] ^ 8'h5A;
    #1;
    check("R6 vpn", 64'(tlb_vpn), 64'(v[47:13]));
    check("R6 asn", 64'(tlb_asn), 64'(v[20:13] ^ 8'h5A));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({"R1 valid ", req}, 64'(rsp_valid), 64'd1);
    check({"R11 fault ", req}, 64'(flt), 64'(e_f));
    check({"R11 uncache ", req}, 64'(uc), 64'(e_uc));
    if (e_f == '0) check({"pa ", req}, pa, e_pa);
  endtask

  initial begin
    #900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(rsp_valid), 64'd0);
    check("R1 reset pa", pa, 64'd0);
    check("R1 reset fault", 64'(flt), 64'd0);
    check("R1 reset uncache", 64'(uc), 64'd0);
    rst_n = 1'b1;

    // R2 privileged code: wins over phys mode and non-canonical addresses
    for (int i = 0; i < 8; i++) begin
      run("R2", (64'hF123_4567_89AB_CDEF ^ (64'(i) << 40)) | 64'd1, i[0], 2'(i), 1'b0, '0, '0);
      run("R2", (64'h0000_0810_0000_0003 + (64'(i) << 5)), 1'b0, 2'd3, 1'b0, '0, '0);
    end

    // R3 physical pass-through with R8, R9, R10
    run("R3", 64'h0000_0012_3456_7890, 1'b1, 2'd2, 1'b0, '0, '0);
    run("R8", 64'h0000_1000_0000_0000, 1'b1, 2'd0, 1'b0, '0, '0);
    run("R8", 64'h8000_0000_0000_0004, 1'b1, 2'd1, 1'b0, '0, '0);
    run("R9", 64'h0000_0810_0000_1234, 1'b1, 2'd0, 1'b0, '0, '0);
    run("R9", 64'h0000_081F_FFFF_FFF8, 1'b1, 2'd3, 1'b0, '0, '0);
    run("R10", 64'h0000_0FFF_FFFF_FFF0, 1'b1, 2'd0, 1'b0, '0, '0);
    run("R10", 64'h0000_0820_0000_0010, 1'b1, 2'd0, 1'b0, '0, '0);

    // R4 non-canonical addresses in every mode
    for (int m = 0; m < 4; m++) begin
      run("R4", 64'h0001_0000_0000_0000, 1'b0, 2'(m), 1'b1, '0, 4'hF);
      run("R4", 64'hFFFE_8000_0000_0000, 1'b0, 2'(m), 1'b1, '0, 4'hF);
    end

    // R5 superpage window, both sign cases, all modes
    for (int m = 0; m < 4; m++) begin
      run("R5", 64'hFFFF_FC00_1234_5678, 1'b0, 2'(m), 1'b0, '0, '0);
      run("R5", 64'hFFFF_FD00_1234_5678, 1'b0, 2'(m), 1'b0, '0, '0);
      run("R5", 64'hFFFF_FCFF_FFFF_FFFC, 1'b0, 2'(m), 1'b0, '0, '0);
    end

    // R6 R7 lookup path: every mode against every enable mask, hit and miss
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 16; r++) begin
        for (int h = 0; h < 2; h++) begin
          run("R7", 64'h0000_1234_5678_9ABE, 1'b0, 2'(m), h[0], 31'h0123_4567, 4'(r));
          run("R10", 64'hFFFF_8000_0000_1FFE, 1'b0, 2'(m), h[0], 31'h7FFF_F00D, 4'(r));
          run("R9", 64'h0000_0000_0000_2002, 1'b0, 2'(m), h[0], {8'h81, 23'h12345}, 4'(r));
        end
      end
    end

    // R1 idle cycle drops valid
    @(negedge clk);
    check("R1 idle", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    check("R1 idle hold", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule